// File: doc/BRIEF.md
# Serial-Bus Master for a 12-bit DAC with Nonvolatile Storage

This block drives an external 12-bit single-channel voltage DAC over a two-wire open-drain serial bus. It is the only master on that bus. It keeps two shadow registers that mirror what the device holds: a 12-bit output code and a 2-bit power-down mode. While automatic update is enabled, any difference between the code and mode inputs and the shadows starts a short volatile write. That write moves the DAC output and then refreshes the shadows. Two request pulses start the longer operations. A store request writes the inputs into the device register and its EEPROM. A recall request reads the device back and loads the stored EEPROM word into the shadows.

Bus timing comes from a set of clock-enable pulses, each at twice the SCL rate it selects, so SCL toggles once per selected pulse. Volatile writes use the rate chosen by the speed select. Store and recall always use the slowest rate. The clock line and the data line are each given as an input, an output held at zero, and a release (tristate) control. Either line is therefore only pulled low or released.

Top module: `dacm_ctrl`

## Requirements
- R1: While reset is high and after it falls, both bus lines are released (`scl_t` = 1, `sda_t` = 1), and `code_sh` and `mode_sh` read zero.
- R2: With `auto_en` high and `{code_in, mode_in}` different from the shadows, the block runs one write: address byte, then `{2'b00, mode, code[11:8]}`, then `code[7:0]`, then STOP. The shadows then take the values that were sent.
- R3: With `auto_en` low, changes on `code_in` or `mode_in` start no bus activity and leave the shadows unchanged.
- R4: With `auto_en` high and the inputs equal to the shadows, no transaction starts.
- R5: A `store_req` pulse runs a write of three bytes after the address: `{3'b011, 2'b00, mode, 1'b0}`, `code[11:4]`, `{code[3:0], 4'b0000}`. On success the shadows take the stored values.
- R6: A `recall_req` pulse sends the address byte with bit 0 = 1 and then reads five bytes. The block ACKs the first four and NACKs the fifth. The shadows load mode = byte4[6:5] and code = {byte4[3:0], byte5}, where byte4 and byte5 are the fourth and fifth bytes read.
- R7: A volatile write clocks the bus on `rate_en[speed_sel]`. The time from one SCL rising edge to the next is two periods of that enable.
- R8: Store and recall clock the bus on `rate_en[0]`, whatever `speed_sel` holds.
- R9: A byte written by the master that is not acknowledged ends the transfer with a STOP. No further bytes are sent and the shadows stay unchanged.
- R10: When several requests are pending, recall goes first, then store, then automatic update.
- R11: The address byte is `{6'b110000, addr_lsb, rw}`.
- R12: SDA changes while SCL is released only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_en | input | NUM_RATES | Clock-enable pulses at twice each SCL rate; index 0 is the slowest |
| speed_sel | input | SEL_W | Rate index used by volatile writes |
| addr_lsb | input | 1 | Low bit of the device address |
| auto_en | input | 1 | Follow the inputs with volatile writes |
| store_req | input | 1 | Pulse: write the inputs into the register and EEPROM |
| recall_req | input | 1 | Pulse: load the shadows from the stored word |
| code_in | input | 12 | Requested output code |
| mode_in | input | 2 | Requested power-down mode |
| code_sh | output | 12 | Shadow of the device code |
| mode_sh | output | 2 | Shadow of the device mode |
| scl_i | input | 1 | Sensed clock line |
| scl_o | output | 1 | Clock line drive value (always 0) |
| scl_t | output | 1 | Clock line release, 1 = released |
| sda_i | input | 1 | Sensed data line |
| sda_o | output | 1 | Data line drive value (always 0) |
| sda_t | output | 1 | Data line release, 1 = released |

## Verification
The bench attaches a behavioural slave that acknowledges only its own address. For each operation it captures the bytes and the rise-to-rise time of SCL. A block that honoured `speed_sel` during a store or recall would show a short clock period where 32 cycles are expected. Swapped byte packing would show up as wrong captured bytes. A recall that loaded the register copy instead of the EEPROM word would leave the wrong shadow value. Four further cases are targeted: a missing acknowledge, simultaneous recall and store requests, inputs that already equal the shadows, and a disabled follow mode. A design that kept sending after a NACK, updated shadows on failure, reversed the priority, or rewrote endlessly would be caught.

// File: rtl/dacm_pkg.sv
package dacm_pkg;
   localparam int CODE_W = 12;
   localparam int PD_W   = 2;

   typedef enum logic [1:0] {ECMD_START, ECMD_WRITE, ECMD_READ, ECMD_STOP} eng_cmd_e;
   typedef enum logic [1:0] {OP_NONE, OP_FAST, OP_STORE, OP_RECALL} dac_op_e;
   typedef enum logic [1:0] {T_IDLE, T_CMD, T_WAIT} seq_e;
   typedef enum logic [3:0] {
      E_IDLE, E_ST_A, E_ST_B, E_WAIT, E_SET, E_LOW, E_HIGH,
      E_SP_SET, E_SP_LOW, E_SP_HIGH
   } eng_st_e;
endpackage

// File: rtl/dacm_rate_pick.sv
module dacm_rate_pick #(
   parameter  int NUM_RATES = 4,
   localparam int SEL_W     = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic [NUM_RATES-1:0] rate_en,
   input  logic [SEL_W-1:0]     sel,
   output logic                 tick
);
   logic [NUM_RATES-1:0] hit;

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_lane
      assign hit[g] = rate_en[g] && (sel == SEL_W'(g));
   end

   assign tick = |hit;
endmodule

// File: rtl/dacm_bit_engine.sv
module dacm_bit_engine
   import dacm_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     tick,
   input  logic     cmd_valid,
   input  eng_cmd_e cmd,
   input  logic [7:0] tx_byte,
   input  logic     ack_out,
   output logic     ready,
   output logic     done,
   output logic [7:0] rx_byte,
   output logic     ack_seen,
   input  logic     scl_i,
   input  logic     sda_i,
   output logic     scl_t,
   output logic     sda_t
);
   eng_st_e    st;
   logic [7:0] shreg;
   logic [3:0] bit_cnt;
   logic       rd_mode;
   logic       ack_drive;

   assign ready   = (st == E_IDLE) || (st == E_WAIT);
   assign rx_byte = shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= E_IDLE;
         scl_t     <= 1'b1;
         sda_t     <= 1'b1;
         done      <= 1'b0;
         ack_seen  <= 1'b0;
         shreg     <= '0;
         bit_cnt   <= '0;
         rd_mode   <= 1'b0;
         ack_drive <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            E_IDLE: if (cmd_valid && cmd == ECMD_START) st <= E_ST_A;
            E_ST_A: if (tick) begin
               sda_t <= 1'b0;
               st    <= E_ST_B;
            end
            E_ST_B: if (tick) begin
               scl_t <= 1'b0;
               done  <= 1'b1;
               st    <= E_WAIT;
            end
            E_WAIT: if (cmd_valid) begin
               if (cmd == ECMD_STOP) begin
                  st <= E_SP_SET;
               end else begin
                  shreg     <= (cmd == ECMD_READ) ? 8'hFF : tx_byte;
                  rd_mode   <= (cmd == ECMD_READ);
                  ack_drive <= ack_out;
                  bit_cnt   <= '0;
                  st        <= E_SET;
               end
            end
            E_SET: begin
               if (bit_cnt == 4'd8) sda_t <= rd_mode ? ~ack_drive : 1'b1;
               else                 sda_t <= rd_mode ? 1'b1 : shreg[7];
               st <= E_LOW;
            end
            E_LOW: if (tick) begin
               scl_t <= 1'b1;
               st    <= E_HIGH;
            end
            E_HIGH: if (tick && scl_i) begin
               scl_t <= 1'b0;
               if (bit_cnt == 4'd8) begin
                  ack_seen <= ~sda_i;
                  done     <= 1'b1;
                  st       <= E_WAIT;
               end else begin
                  shreg   <= {shreg[6:0], sda_i};
                  bit_cnt <= bit_cnt + 4'd1;
                  st      <= E_SET;
               end
            end
            E_SP_SET: begin
               sda_t <= 1'b0;
               st    <= E_SP_LOW;
            end
            E_SP_LOW: if (tick) begin
               scl_t <= 1'b1;
               st    <= E_SP_HIGH;
            end
            E_SP_HIGH: if (tick) begin
               sda_t <= 1'b1;
               done  <= 1'b1;
               st    <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // R12
   sda_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (scl_t && $past(scl_t) && (sda_t != $past(sda_t)))
         |-> ($past(st) == E_ST_A || $past(st) == E_SP_HIGH))
      else $error("data line moved while clock released");
endmodule

// File: rtl/dacm_ctrl.sv
module dacm_ctrl
   import dacm_pkg::*;
#(
   parameter  int         NUM_RATES   = 4,
   parameter  int         MEM_RATE    = 0,
   parameter  logic [5:0] DEV_ADDR_HI = 6'b110000,
   localparam int         SEL_W       = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_RATES-1:0] rate_en,
   input  logic [SEL_W-1:0]     speed_sel,
   input  logic                 addr_lsb,
   input  logic                 auto_en,
   input  logic                 store_req,
   input  logic                 recall_req,
   input  logic [CODE_W-1:0]    code_in,
   input  logic [PD_W-1:0]      mode_in,
   output logic [CODE_W-1:0]    code_sh,
   output logic [PD_W-1:0]      mode_sh,
   input  logic                 scl_i,
   output logic                 scl_o,
   output logic                 scl_t,
   input  logic                 sda_i,
   output logic                 sda_o,
   output logic                 sda_t
);
   if (MEM_RATE < 0 || MEM_RATE >= NUM_RATES) begin : g_bad_rate
      $error("MEM_RATE must index rate_en");
   end
   if (CODE_W != 12 || PD_W != 2) begin : g_bad_fmt
      $error("byte packing assumes a 12-bit code and a 2-bit mode");
   end

   seq_e              tst;
   dac_op_e           op_q, go_op;
   logic [CODE_W-1:0] code_q;
   logic [PD_W-1:0]   mode_q;
   logic              addr_q, fail_q, rd_pend, st_pend;
   logic [SEL_W-1:0]  spd_q;
   logic [2:0]        step, last_step;
   logic [7:0]        ee_hi, ee_lo;
   logic              tick, stop_step, wr_step;
   logic              eng_valid, eng_ready, eng_done, eng_ack, eng_ackout;
   eng_cmd_e          eng_cmd;
   logic [7:0]        eng_tx, eng_rx;

   assign scl_o = 1'b0;
   assign sda_o = 1'b0;

   dacm_rate_pick #(.NUM_RATES(NUM_RATES)) u_rate (
      .rate_en(rate_en), .sel(spd_q), .tick(tick));

   dacm_bit_engine u_eng (
      .clk(clk), .rst(rst), .tick(tick),
      .cmd_valid(eng_valid), .cmd(eng_cmd), .tx_byte(eng_tx), .ack_out(eng_ackout),
      .ready(eng_ready), .done(eng_done), .rx_byte(eng_rx), .ack_seen(eng_ack),
      .scl_i(scl_i), .sda_i(sda_i), .scl_t(scl_t), .sda_t(sda_t));

   always_comb begin
      if (rd_pend)      go_op = OP_RECALL;
      else if (st_pend) go_op = OP_STORE;
      else if (auto_en && (code_in != code_sh || mode_in != mode_sh)) go_op = OP_FAST;
      else              go_op = OP_NONE;
   end

   always_comb begin
      unique case (op_q)
         OP_FAST:  last_step = 3'd3;
         OP_STORE: last_step = 3'd4;
         default:  last_step = 3'd6;
      endcase
   end

   assign stop_step = (step == last_step + 3'd1);
   assign wr_step   = (step != 3'd0) && !stop_step && (op_q != OP_RECALL || step == 3'd1);
   assign eng_valid = (tst == T_CMD);

   always_comb begin
      eng_cmd    = ECMD_WRITE;
      eng_tx     = 8'h00;
      eng_ackout = 1'b0;
      if (step == 3'd0) begin
         eng_cmd = ECMD_START;
      end else if (stop_step) begin
         eng_cmd = ECMD_STOP;
      end else if (step == 3'd1) begin
         eng_tx = {DEV_ADDR_HI, addr_q, op_q == OP_RECALL};
      end else if (op_q == OP_RECALL) begin
         eng_cmd    = ECMD_READ;
         eng_ackout = (step != last_step);
      end else if (op_q == OP_FAST) begin
         eng_tx = (step == 3'd2) ? {2'b00, mode_q, code_q[11:8]} : code_q[7:0];
      end else begin
         unique case (step)
            3'd2:    eng_tx = {3'b011, 2'b00, mode_q, 1'b0};
            3'd3:    eng_tx = code_q[11:4];
            default: eng_tx = {code_q[3:0], 4'b0000};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tst     <= T_IDLE;
         op_q    <= OP_NONE;
         code_q  <= '0;
         mode_q  <= '0;
         addr_q  <= 1'b0;
         spd_q   <= '0;
         step    <= '0;
         fail_q  <= 1'b0;
         rd_pend <= 1'b0;
         st_pend <= 1'b0;
         ee_hi   <= '0;
         ee_lo   <= '0;
         code_sh <= '0;
         mode_sh <= '0;
      end else begin
         rd_pend <= (rd_pend && !(tst == T_IDLE && go_op == OP_RECALL)) || recall_req;
         st_pend <= (st_pend && !(tst == T_IDLE && go_op == OP_STORE)) || store_req;
         unique case (tst)
            T_IDLE: if (go_op != OP_NONE) begin
               op_q   <= go_op;
               code_q <= code_in;
               mode_q <= mode_in;
               addr_q <= addr_lsb;
               spd_q  <= (go_op == OP_FAST) ? speed_sel : SEL_W'(MEM_RATE);
               step   <= '0;
               fail_q <= 1'b0;
               tst    <= T_CMD;
            end
            T_CMD: tst <= T_WAIT;
            T_WAIT: if (eng_done) begin
               if (stop_step) begin
                  tst <= T_IDLE;
                  if (!fail_q) begin
                     if (op_q == OP_RECALL) begin
                        code_sh <= {ee_hi[3:0], ee_lo};
                        mode_sh <= ee_hi[6:5];
                     end else begin
                        code_sh <= code_q;
                        mode_sh <= mode_q;
                     end
                  end
               end else begin
                  tst <= T_CMD;
                  if (wr_step && !eng_ack) begin
                     fail_q <= 1'b1;
                     step   <= last_step + 3'd1;
                  end else begin
                     step <= step + 3'd1;
                  end
                  if (op_q == OP_RECALL && step == last_step - 3'd1) ee_hi <= eng_rx;
                  if (op_q == OP_RECALL && step == last_step)        ee_lo <= eng_rx;
               end
            end
            default: tst <= T_IDLE;
         endcase
      end
   end

   // R2
   cmd_ready_chk: assert property (@(posedge clk) disable iff (rst)
      eng_valid |-> eng_ready)
      else $error("command offered to a busy engine");

   // R8
   mem_rate_chk: assert property (@(posedge clk) disable iff (rst)
      (tst != T_IDLE && op_q != OP_FAST) |-> (spd_q == SEL_W'(MEM_RATE)))
      else $error("memory operation on a fast rate");

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (code_sh != $past(code_sh) || mode_sh != $past(mode_sh))
         |-> ($past(eng_done) && $past(tst) == T_WAIT && !$past(fail_q)))
      else $error("shadow changed outside a finished transfer");
endmodule

// File: tb/tb_dacm_ctrl.sv
module tb_dacm_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  rate_en = '0;
   logic [1:0]  speed_sel = '0;
   logic        addr_lsb = 1'b0, auto_en = 1'b0, store_req = 1'b0, recall_req = 1'b0;
   logic [11:0] code_in = '0;
   logic [1:0]  mode_in = '0;
   logic [11:0] code_sh;
   logic [1:0]  mode_sh;
   logic        scl_o, scl_t, sda_o, sda_t;
   logic        scl_ln, sda_ln;
   logic        sl_low = 1'b0;

   int checks = 0, errors = 0;
   int cyc = 0;

   assign scl_ln = scl_t ? 1'b1 : scl_o;
   assign sda_ln = (sda_t ? 1'b1 : sda_o) & ~sl_low;

   dacm_ctrl dut (
      .clk(clk), .rst(rst), .rate_en(rate_en), .speed_sel(speed_sel),
      .addr_lsb(addr_lsb), .auto_en(auto_en), .store_req(store_req),
      .recall_req(recall_req), .code_in(code_in), .mode_in(mode_in),
      .code_sh(code_sh), .mode_sh(mode_sh),
      .scl_i(scl_ln), .scl_o(scl_o), .scl_t(scl_t),
      .sda_i(sda_ln), .sda_o(sda_o), .sda_t(sda_t));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      forever begin
         @(negedge clk);
         for (int k = 0; k < 4; k++) rate_en[k] = ((cyc % (2 << (3 - k))) == 0);
      end
   end

   // behavioural slave
   logic        slave_a0 = 1'b0;
   logic [11:0] dr_code = 12'h111, ee_code = 12'h000;
   logic [1:0]  dr_mode = 2'd1,    ee_mode = 2'd0;
   int          bit_idx = 9, byte_idx = 0, nbytes = 0;
   int          start_cnt = 0, stop_cnt = 0, t1 = 0, t2 = 0;
   logic [7:0]  cur = '0;
   logic [7:0]  got [0:7];
   logic [4:0]  mack = '0;
   logic        reading = 1'b0, addressed = 1'b0, rd_done = 1'b0;

   function automatic logic [7:0] rd_byte(input int i);
      case (i)
         0:       return {2'b11, 3'b000, dr_mode, 1'b0};
         1:       return dr_code[11:4];
         2:       return {dr_code[3:0], 4'b0000};
         3:       return {1'b0, ee_mode, 1'b0, ee_code[11:8]};
         default: return ee_code[7:0];
      endcase
   endfunction

   always @(negedge sda_ln) if (scl_ln === 1'b1) begin
      start_cnt++; bit_idx = 9; byte_idx = 0; nbytes = 0;
      reading = 1'b0; addressed = 1'b0; rd_done = 1'b0; mack = '0; sl_low = 1'b0;
   end

   always @(posedge sda_ln) if (scl_ln === 1'b1) stop_cnt++;

   always @(posedge scl_ln) begin
      if (bit_idx < 8) begin
         cur = {cur[6:0], sda_ln};
         if (byte_idx == 0 && bit_idx == 1) t1 = cyc;
         if (byte_idx == 0 && bit_idx == 2) t2 = cyc;
         if (bit_idx == 7) begin
            got[byte_idx] = cur;
            nbytes = byte_idx + 1;
            if (byte_idx == 0) begin
               reading   = cur[0];
               addressed = (cur[7:1] == {6'b110000, slave_a0});
            end
         end
      end else if (bit_idx == 8) begin
         if (reading && byte_idx > 0) begin
            mack[byte_idx-1] = ~sda_ln;
            if (sda_ln) rd_done = 1'b1;
         end
         byte_idx++;
      end
   end

   always @(negedge scl_ln) begin
      if (bit_idx >= 8) bit_idx = 0; else bit_idx++;
      sl_low = 1'b0;
      if (addressed && !rd_done) begin
         if (bit_idx == 8 && !(reading && byte_idx > 0)) sl_low = 1'b1;
         else if (bit_idx < 8 && reading && byte_idx > 0) begin
            logic [7:0] b;
            b = rd_byte(byte_idx - 1);
            sl_low = ~b[7 - bit_idx];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_stop(input int target, input string tag);
      int n = 0;
      while (stop_cnt < target && n < 20000) begin @(negedge clk); n++; end
      if (stop_cnt < target) chk({tag, " stop timeout"}, 0, 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_store();  store_req = 1'b1;  @(negedge clk); store_req = 1'b0;  endtask
   task automatic pulse_recall(); recall_req = 1'b1; @(negedge clk); recall_req = 1'b0; endtask

   task automatic t_reset();
      chk("R1 scl released", scl_t, 1);
      chk("R1 sda released", sda_t, 1);
      chk("R1 shadow code",  code_sh, 0);
      chk("R1 shadow mode",  mode_sh, 0);
   endtask

   task automatic t_follow(input logic [11:0] c, input logic [1:0] m, input logic [1:0] spd,
                           input logic a, input int period);
      int s0 = stop_cnt;
      speed_sel = spd; addr_lsb = a; slave_a0 = a;
      code_in = c; mode_in = m; auto_en = 1'b1;
      wait_stop(s0 + 1, "R2");
      auto_en = 1'b0;
      chk("R2 byte count", nbytes, 3);
      chk("R11 address byte", got[0], {6'b110000, a, 1'b0});
      chk("R2 first byte", got[1], {2'b00, m, c[11:8]});
      chk("R2 second byte", got[2], c[7:0]);
      chk("R2 shadow code", code_sh, c);
      chk("R2 shadow mode", mode_sh, m);
      chk("R7 scl period", t2 - t1, period);
   endtask

   task automatic t_no_repeat();
      int s0 = start_cnt;
      auto_en = 1'b1;
      repeat (2000) @(negedge clk);
      chk("R4 no restart when equal", start_cnt, s0);
      auto_en = 1'b0;
   endtask

   task automatic t_disabled();
      int s0 = start_cnt;
      logic [11:0] c0 = code_sh;
      code_in = ~code_sh; mode_in = ~mode_sh;
      repeat (2000) @(negedge clk);
      chk("R3 no bus activity", start_cnt, s0);
      chk("R3 shadow kept", code_sh, c0);
   endtask

   task automatic t_store(input logic [11:0] c, input logic [1:0] m);
      int s0 = stop_cnt;
      speed_sel = 2'd3; slave_a0 = addr_lsb;
      code_in = c; mode_in = m;
      pulse_store();
      wait_stop(s0 + 1, "R5");
      chk("R5 byte count", nbytes, 4);
      chk("R5 command byte", got[1], {3'b011, 2'b00, m, 1'b0});
      chk("R5 high byte", got[2], c[11:4]);
      chk("R5 low byte", got[3], {c[3:0], 4'b0000});
      chk("R5 shadow code", code_sh, c);
      chk("R5 shadow mode", mode_sh, m);
      chk("R8 store rate", t2 - t1, 32);
   endtask

   task automatic t_recall();
      int s0 = stop_cnt;
      speed_sel = 2'd3;
      dr_code = 12'h111; dr_mode = 2'd1; ee_code = 12'hBEE; ee_mode = 2'd2;
      pulse_recall();
      wait_stop(s0 + 1, "R6");
      chk("R6 read address", got[0], {6'b110000, addr_lsb, 1'b1});
      chk("R6 master acks", mack, 5'b01111);
      chk("R6 shadow code", code_sh, 12'hBEE);
      chk("R6 shadow mode", mode_sh, 2'd2);
      chk("R8 recall rate", t2 - t1, 32);
   endtask

   task automatic t_nack();
      int s0 = stop_cnt;
      logic [11:0] c0 = code_sh;
      logic [1:0]  m0 = mode_sh;
      slave_a0 = 1'b0; addr_lsb = 1'b1;
      code_in = 12'h777; mode_in = 2'd3;
      pulse_store();
      wait_stop(s0 + 1, "R9");
      chk("R9 stopped after address", nbytes, 1);
      chk("R9 shadow code kept", code_sh, c0);
      chk("R9 shadow mode kept", mode_sh, m0);
   endtask

   task automatic t_priority();
      int s0 = stop_cnt;
      slave_a0 = 1'b1; addr_lsb = 1'b1;
      ee_code = 12'h456; ee_mode = 2'd1;
      code_in = 12'h9AB; mode_in = 2'd3;
      store_req = 1'b1; recall_req = 1'b1;
      @(negedge clk);
      store_req = 1'b0; recall_req = 1'b0;
      wait_stop(s0 + 1, "R10");
      chk("R10 recall first", got[0], 8'hC3);
      chk("R10 recall result", code_sh, 12'h456);
      wait_stop(s0 + 2, "R10");
      chk("R10 store second", got[0], 8'hC2);
      chk("R10 store result", code_sh, 12'h9AB);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_follow(12'hA5C, 2'd2, 2'd1, 1'b0, 16);
      t_no_repeat();
      t_disabled();
      t_follow(12'h3F1, 2'd1, 2'd3, 1'b0, 4);
      t_store(12'h123, 2'd3);
      t_recall();
      t_follow(12'h0F0, 2'd0, 2'd2, 1'b1, 8);
      t_nack();
      t_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule